// File: doc/BRIEF.md
# Keyed MAC Command Sequencer

This block is the control front end of a keyed-hash accelerator. Software drives it with single-word register writes. It opens a session, names a hardware key slot and the use the result is meant for, and has that pairing checked against the use recorded for the slot. It then feeds message blocks of sixteen 32-bit words, and at the end either reads back a 256-bit result or leaves it for a downstream consumer. The compression engine is outside the block. The sequencer hands it one block at a time over a start/done handshake, with a tag that marks the block as the opening block, a middle block or the final padded block.

The block tracks a small set of phases: idle, configuring, checking, waiting for a block, running, between blocks, and result held. In any phase it accepts only the commands that belong there. A command written in the wrong phase has no effect and latches a sticky sequence-error flag. A failed configuration check raises a configuration error and returns the block to idle with the key, purpose and result registers cleared. The finish command does the same clearing after a successful run.

Top module: `keyed_mac_seq`

Write offsets: 0 open session, 1 purpose, 2 key slot, 3 configuration done, 4 run block, 5 next block is normal, 6 next block is padded final, 7 single-block finish, 8 result finish, 9 drop signature-consumer flag, 10 drop debug-consumer flag, 16..31 message words 0..15. Read offsets: 0 status, 32..39 result words 0..7.

## Requirements
- R1: After reset the status word (bit0 busy, bit1 configuration error, bit2 sequence error, bit3 signature-consumer valid, bit4 debug-consumer valid) reads 0, and every result word reads 0.
- R2: Purpose and key-slot writes take effect only after an open-session write and before configuration done; outside that phase they are ignored.
- R3: Configuration done holds busy for one check cycle. A key slot of 6 or more sets the configuration error, returns the block to idle and leaves the result reading 0.
- R4: When the written purpose differs from the purpose stored for the chosen slot, the configuration error is set. When it matches, the error reads 0 and the block waits for a message block. Purpose codes: 8 user readback, 7 signature consumer, 6 debug enable, 5 both consumers.
- R5: The run-block write pulses engine start for one cycle with the sixteen loaded words (word i in bits 32i+31..32i), the key slot and a block tag. The first block of a session is tagged 0. Busy stays high until engine done.
- R6: A next-normal write between blocks tags the following block 1. A next-padded write tags it 2, and completion of the tagged-2 block makes the result available.
- R7: A single-block finish after exactly one processed block makes the result available. After more than one block it is a sequence error and is ignored.
- R8: Result words read the engine's last digest (word i from bits 32i+31..32i) only while a result is held under purpose 8, and read 0 otherwise. Completion under purpose 7 sets the signature flag, under 6 the debug flag, and under 5 both.
- R9: Result finish with data 2 clears the result and returns the block to idle. Any other data value is ignored.
- R10: The two drop writes clear the signature and the debug flag in any phase.
- R11: A control write in the wrong phase is ignored: no engine start and no phase change. It sets a sequence-error flag that stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 6 | Write offset |
| wrData | input | 32 | Write data |
| rdAddr | input | 6 | Read offset |
| rdData | output | 32 | Read data, combinational |
| slotPurpose | input | 24 | Stored purpose per slot, slot s in bits 4s+3..4s |
| engStart | output | 1 | One-cycle engine start |
| engBlockType | output | 2 | Block tag: 0 first, 1 normal, 2 padded final |
| engKeySlot | output | 3 | Selected key slot |
| engBlock | output | 512 | Message block for the engine |
| engDone | input | 1 | Engine finished the block |
| engDigest | input | 256 | Engine digest, valid with engDone |
| busy | output | 1 | Check or block processing under way |
| sigValid | output | 1 | Result delivered to signature consumer |
| dbgValid | output | 1 | Result delivered to debug-enable consumer |

## Verification
The hardest state to reach is the between-blocks phase after several blocks. Only there can a single-block finish be rejected while padding is still accepted. The stimulus runs a full three-block session through an engine model that answers a few cycles after each start. Inside that session it issues the illegal single-block finish, then the padded tag, and checks the tag sequence the engine saw. It also checks that the final digest becomes readable. A table of purpose and slot pairs covers every consumer flag and both kinds of configuration failure.

// File: rtl/keyed_mac_pkg.sv
package keyed_mac_pkg;

  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_START   = 6'd0;
  localparam logic [ADDR_W-1:0] A_PURPOSE = 6'd1;
  localparam logic [ADDR_W-1:0] A_KEY     = 6'd2;
  localparam logic [ADDR_W-1:0] A_CFGDONE = 6'd3;
  localparam logic [ADDR_W-1:0] A_RUN     = 6'd4;
  localparam logic [ADDR_W-1:0] A_NEXT    = 6'd5;
  localparam logic [ADDR_W-1:0] A_PAD     = 6'd6;
  localparam logic [ADDR_W-1:0] A_ONEBLK  = 6'd7;
  localparam logic [ADDR_W-1:0] A_RESFIN  = 6'd8;
  localparam logic [ADDR_W-1:0] A_INVSIG  = 6'd9;
  localparam logic [ADDR_W-1:0] A_INVDBG  = 6'd10;
  localparam int MSG_BASE = 16;
  localparam int RES_BASE = 32;

  localparam int PURP_USER = 8;
  localparam int PURP_SIG  = 7;
  localparam int PURP_DBG  = 6;
  localparam int PURP_BOTH = 5;

  localparam int FIN_CODE = 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CONFIG, PH_CHECK, PH_LOAD, PH_RUN, PH_BLKDONE, PH_RESULT
  } phase_t;

  typedef enum logic [1:0] {
    BT_FIRST = 2'd0, BT_NORMAL = 2'd1, BT_PADDED = 2'd2
  } blk_t;

  typedef struct packed {
    logic capPurpose;
    logic capKey;
    logic capWord;
    logic latchDigest;
    logic scrub;
    logic setValid;
    logic invSig;
    logic invDbg;
    logic resultOpen;
  } seqStb_t;

endpackage

// File: rtl/keyed_mac_ctrl.sv
module keyed_mac_ctrl
  import keyed_mac_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              cfgOk,
  input  logic              engDone,
  output seqStb_t           stb,
  output logic              engStart,
  output logic [1:0]        engBlockType,
  output logic              busy,
  output logic              cfgErr,
  output logic              seqErr
);

  phase_t phase, phaseNxt;
  blk_t   curType, nextType, nextTypeNxt;
  logic   multiBlk, multiBlkNxt;
  logic   finalBlk, finalBlkNxt;
  logic   startNxt;
  logic   cfgErrSet, cfgErrClr;
  logic   accepted;
  logic   isCtl;

  // control writes are offsets START..RESFIN; drops are phase-free
  assign isCtl = wrEn && (wrAddr <= A_RESFIN);

  always_comb begin
    phaseNxt    = phase;
    nextTypeNxt = nextType;
    multiBlkNxt = multiBlk;
    finalBlkNxt = finalBlk;
    startNxt    = 1'b0;
    cfgErrSet   = 1'b0;
    cfgErrClr   = 1'b0;
    accepted    = 1'b0;
    stb         = '0;
    stb.invSig     = wrEn && (wrAddr == A_INVSIG);
    stb.invDbg     = wrEn && (wrAddr == A_INVDBG);
    stb.resultOpen = (phase == PH_RESULT);
    stb.capWord    = wrEn && (phase == PH_LOAD) &&
                     (wrAddr >= ADDR_W'(MSG_BASE)) &&
                     (wrAddr <  ADDR_W'(MSG_BASE + BLK_WORDS));
    unique case (phase)
      PH_IDLE: begin
        if (wrEn && wrAddr == A_START) begin
          accepted  = 1'b1;
          cfgErrClr = 1'b1;
          phaseNxt  = PH_CONFIG;
        end
      end
      PH_CONFIG: begin
        if (wrEn && wrAddr == A_PURPOSE) begin
          accepted = 1'b1;
          stb.capPurpose = 1'b1;
        end else if (wrEn && wrAddr == A_KEY) begin
          accepted = 1'b1;
          stb.capKey = 1'b1;
        end else if (wrEn && wrAddr == A_CFGDONE) begin
          accepted = 1'b1;
          phaseNxt = PH_CHECK;
        end
      end
      PH_CHECK: begin
        if (cfgOk) begin
          phaseNxt    = PH_LOAD;
          nextTypeNxt = BT_FIRST;
          multiBlkNxt = 1'b0;
        end else begin
          cfgErrSet = 1'b1;
          stb.scrub = 1'b1;
          phaseNxt  = PH_IDLE;
        end
      end
      PH_LOAD: begin
        if (wrEn && wrAddr == A_RUN) begin
          accepted    = 1'b1;
          startNxt    = 1'b1;
          finalBlkNxt = (nextType == BT_PADDED);
          phaseNxt    = PH_RUN;
        end
      end
      PH_RUN: begin
        if (engDone) begin
          stb.latchDigest = 1'b1;
          if (finalBlk) begin
            stb.setValid = 1'b1;
            phaseNxt     = PH_RESULT;
          end else begin
            phaseNxt = PH_BLKDONE;
          end
        end
      end
      PH_BLKDONE: begin
        if (wrEn && wrAddr == A_NEXT) begin
          accepted    = 1'b1;
          nextTypeNxt = BT_NORMAL;
          multiBlkNxt = 1'b1;
          phaseNxt    = PH_LOAD;
        end else if (wrEn && wrAddr == A_PAD) begin
          accepted    = 1'b1;
          nextTypeNxt = BT_PADDED;
          multiBlkNxt = 1'b1;
          phaseNxt    = PH_LOAD;
        end else if (wrEn && wrAddr == A_ONEBLK && !multiBlk) begin
          accepted     = 1'b1;
          stb.setValid = 1'b1;
          phaseNxt     = PH_RESULT;
        end
      end
      PH_RESULT: begin
        if (wrEn && wrAddr == A_RESFIN) begin
          accepted = 1'b1;
          if (wrData == WORD_W'(FIN_CODE)) begin
            stb.scrub = 1'b1;
            phaseNxt  = PH_IDLE;
          end
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      nextType <= BT_FIRST;
      curType  <= BT_FIRST;
      multiBlk <= 1'b0;
      finalBlk <= 1'b0;
      engStart <= 1'b0;
      cfgErr   <= 1'b0;
      seqErr   <= 1'b0;
    end else begin
      phase    <= phaseNxt;
      nextType <= nextTypeNxt;
      multiBlk <= multiBlkNxt;
      finalBlk <= finalBlkNxt;
      engStart <= startNxt;
      if (startNxt) curType <= nextType;
      if (cfgErrSet) cfgErr <= 1'b1;
      else if (cfgErrClr) cfgErr <= 1'b0;
      if (isCtl && !accepted) seqErr <= 1'b1;
    end
  end

  assign engBlockType = curType;
  assign busy = (phase == PH_CHECK) || (phase == PH_RUN);

endmodule

// File: rtl/keyed_mac_dpath.sv
module keyed_mac_dpath
  import keyed_mac_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 16,
  parameter int RES_WORDS = 8,
  parameter int NUM_SLOTS = 6,
  parameter int PURP_W    = 4,
  localparam int KEY_W    = $clog2(NUM_SLOTS),
  localparam int BLK_W    = BLK_WORDS * WORD_W,
  localparam int RES_W    = RES_WORDS * WORD_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStb_t                     stb,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [WORD_W-1:0]           wrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  input  logic [NUM_SLOTS*PURP_W-1:0] slotPurpose,
  input  logic [RES_W-1:0]            engDigest,
  output logic                        cfgOk,
  output logic [KEY_W-1:0]            engKeySlot,
  output logic [BLK_W-1:0]            engBlock,
  output logic [WORD_W-1:0]           rdResult,
  output logic                        sigValid,
  output logic                        dbgValid
);

  logic [WORD_W-1:0] purposeReg;
  logic [WORD_W-1:0] keyReg;
  logic [RES_W-1:0]  resultReg;
  logic [PURP_W-1:0] slotSel;

  // stored purpose of the selected slot; out-of-range slots match nothing
  always_comb begin
    slotSel = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (keyReg == WORD_W'(s)) slotSel = slotPurpose[s*PURP_W +: PURP_W];
    end
  end

  assign cfgOk = (keyReg < WORD_W'(NUM_SLOTS)) &&
                 (purposeReg == WORD_W'(slotSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      purposeReg <= '0;
      keyReg     <= '0;
      resultReg  <= '0;
    end else if (stb.scrub) begin
      purposeReg <= '0;
      keyReg     <= '0;
      resultReg  <= '0;
    end else begin
      if (stb.capPurpose)  purposeReg <= wrData;
      if (stb.capKey)      keyReg     <= wrData;
      if (stb.latchDigest) resultReg  <= engDigest;
    end
  end

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_msg
    logic [WORD_W-1:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        word <= '0;
      else if (stb.scrub)                               word <= '0;
      else if (stb.capWord && wrAddr == ADDR_W'(MSG_BASE + g)) word <= wrData;
    end
    assign engBlock[g*WORD_W +: WORD_W] = word;
  end

  // drop requests take priority over a same-cycle delivery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigValid <= 1'b0;
      dbgValid <= 1'b0;
    end else begin
      if (stb.invSig) sigValid <= 1'b0;
      else if (stb.setValid && (purposeReg == WORD_W'(PURP_SIG) ||
                                purposeReg == WORD_W'(PURP_BOTH)))
        sigValid <= 1'b1;
      if (stb.invDbg) dbgValid <= 1'b0;
      else if (stb.setValid && (purposeReg == WORD_W'(PURP_DBG) ||
                                purposeReg == WORD_W'(PURP_BOTH)))
        dbgValid <= 1'b1;
    end
  end

  assign engKeySlot = keyReg[KEY_W-1:0];

  always_comb begin
    rdResult = '0;
    if (stb.resultOpen && purposeReg == WORD_W'(PURP_USER)) begin
      for (int i = 0; i < RES_WORDS; i++) begin
        if (rdAddr == ADDR_W'(RES_BASE + i)) rdResult = resultReg[i*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/keyed_mac_seq.sv
module keyed_mac_seq
  import keyed_mac_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 16,
  parameter int RES_WORDS = 8,
  parameter int NUM_SLOTS = 6,
  parameter int PURP_W    = 4,
  localparam int KEY_W    = $clog2(NUM_SLOTS),
  localparam int BLK_W    = BLK_WORDS * WORD_W,
  localparam int RES_W    = RES_WORDS * WORD_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [WORD_W-1:0]           wrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [WORD_W-1:0]           rdData,
  input  logic [NUM_SLOTS*PURP_W-1:0] slotPurpose,
  output logic                        engStart,
  output logic [1:0]                  engBlockType,
  output logic [KEY_W-1:0]            engKeySlot,
  output logic [BLK_W-1:0]            engBlock,
  input  logic                        engDone,
  input  logic [RES_W-1:0]            engDigest,
  output logic                        busy,
  output logic                        sigValid,
  output logic                        dbgValid
);

  seqStb_t           stb;
  logic              cfgOk, cfgErr, seqErr, resultOpen;
  logic [WORD_W-1:0] rdResult;

  assign resultOpen = stb.resultOpen;

  keyed_mac_ctrl #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfgOk(cfgOk), .engDone(engDone), .stb(stb), .engStart(engStart),
    .engBlockType(engBlockType), .busy(busy), .cfgErr(cfgErr), .seqErr(seqErr)
  );

  keyed_mac_dpath #(
    .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .RES_WORDS(RES_WORDS),
    .NUM_SLOTS(NUM_SLOTS), .PURP_W(PURP_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .slotPurpose(slotPurpose), .engDigest(engDigest),
    .cfgOk(cfgOk), .engKeySlot(engKeySlot), .engBlock(engBlock),
    .rdResult(rdResult), .sigValid(sigValid), .dbgValid(dbgValid)
  );

  always_comb begin
    if (rdAddr == '0)
      rdData = WORD_W'({dbgValid, sigValid, seqErr, cfgErr, busy});
    else
      rdData = rdResult;
  end

endmodule

// File: rtl/keyed_mac_chk.sv
module keyed_mac_chk
  import keyed_mac_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [WORD_W-1:0] rdData,
  input logic              engStart,
  input logic              busy,
  input logic              cfgErr,
  input logic              seqErr,
  input logic              sigValid,
  input logic              dbgValid,
  input logic              resultOpen
);

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> busy);

  p_cfg_err_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErr) |-> !busy);

  p_hidden_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!resultOpen && rdAddr >= ADDR_W'(RES_BASE)) |-> rdData == '0);

  p_drop_sig_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_INVSIG) |=> !sigValid);

  p_drop_dbg_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_INVDBG) |=> !dbgValid);

  p_seq_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |=> seqErr);

endmodule

bind keyed_mac_seq keyed_mac_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
  .rdData(rdData), .engStart(engStart), .busy(busy), .cfgErr(cfgErr),
  .seqErr(seqErr), .sigValid(sigValid), .dbgValid(dbgValid),
  .resultOpen(resultOpen)
);

// File: tb/sim_keyed_mac_seq.sv
module sim_keyed_mac_seq;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [5:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic [5:0]   rdAddr = '0;
  logic [31:0]  rdData;
  logic [23:0]  slotPurpose;
  logic         engStart;
  logic [1:0]   engBlockType;
  logic [2:0]   engKeySlot;
  logic [511:0] engBlock;
  logic         engDone = 1'b0;
  logic [255:0] engDigest = '0;
  logic         busy, sigValid, dbgValid;

  int nChecks = 0;
  int nErrors = 0;
  int startCount = 0;
  int engCnt = 0;
  logic [1:0] lastType = '0;
  logic [31:0] lastBase = '0;

  // slot purposes: 0:8 1:7 2:6 3:5 4:8 5:7
  assign slotPurpose = {4'd7, 4'd8, 4'd5, 4'd6, 4'd7, 4'd8};

  always #4 clk = ~clk;

  keyed_mac_seq u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .slotPurpose(slotPurpose),
    .engStart(engStart), .engBlockType(engBlockType), .engKeySlot(engKeySlot),
    .engBlock(engBlock), .engDone(engDone), .engDigest(engDigest),
    .busy(busy), .sigValid(sigValid), .dbgValid(dbgValid)
  );

  function automatic logic [31:0] digWord(logic [31:0] b, logic [1:0] t, int i);
    return b + 32'(i) * 32'h11 + (32'(t) << 16);
  endfunction

  // engine model: answers three cycles after a start
  always @(negedge clk) begin
    engDone <= 1'b0;
    if (engStart) begin
      startCount <= startCount + 1;
      lastType   <= engBlockType;
      lastBase   <= engBlock[31:0];
      for (int i = 0; i < 8; i++)
        engDigest[i*32 +: 32] <= digWord(engBlock[31:0], engBlockType, i);
      engCnt <= 3;
    end else if (engCnt > 0) begin
      engCnt <= engCnt - 1;
      if (engCnt == 1) engDone <= 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int k = 0; k < 50; k++) begin
      rd(6'd0, s);
      if (!s[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic configure(input logic [31:0] p, input logic [31:0] k);
    wr(6'd0, 0); wr(6'd1, p); wr(6'd2, k); wr(6'd3, 0);
    waitIdle();
  endtask

  task automatic loadBlock(input logic [31:0] base);
    for (int i = 0; i < 16; i++) wr(6'(16 + i), base + 32'(i));
    wr(6'd4, 0);
    waitIdle();
  endtask

  // {purpose, key slot, expect configuration error}
  localparam logic [7:0][11:0] VECS = {
    {4'd7, 4'd7, 4'd1}, {4'd8, 4'd6, 4'd1}, {4'd8, 4'd4, 4'd0}, {4'd5, 4'd3, 4'd0},
    {4'd6, 4'd2, 4'd0}, {4'd7, 4'd1, 4'd0}, {4'd8, 4'd1, 4'd1}, {4'd8, 4'd0, 4'd0}
  };

  initial begin
    #800000;
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] s, r;
    int sc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'd0, s);  chk("R1 status", s, 0);
    rd(6'd32, r); chk("R1 result0", r, 0);
    rd(6'd39, r); chk("R1 result7", r, 0);

    for (int v = 0; v < 8; v++) begin
      logic [3:0] p, k;
      logic       e;
      logic [31:0] base;
      p = VECS[v][11:8]; k = VECS[v][7:4]; e = VECS[v][0];
      base = 32'h1000 * 32'(v + 1);
      configure(32'(p), 32'(k));
      rd(6'd0, s);
      chk($sformatf("R3 R4 vec%0d cfgErr", v), 32'(s[1]), 32'(e));
      chk($sformatf("R3 vec%0d busy", v), 32'(s[0]), 0);
      if (e) begin
        rd(6'd32, r); chk($sformatf("R3 vec%0d result hidden", v), r, 0);
      end else begin
        loadBlock(base);
        chk($sformatf("R5 vec%0d tag", v), 32'(lastType), 0);
        chk($sformatf("R5 vec%0d word0", v), lastBase, base);
        wr(6'd7, 0);
        rd(6'd32, r);
        chk($sformatf("R8 vec%0d r0", v), r, (p == 8) ? digWord(base, 0, 0) : 0);
        rd(6'd39, r);
        chk($sformatf("R8 vec%0d r7", v), r, (p == 8) ? digWord(base, 0, 7) : 0);
        rd(6'd0, s);
        chk($sformatf("R8 vec%0d sig", v), 32'(s[3]), 32'(p == 7 || p == 5));
        chk($sformatf("R8 vec%0d dbg", v), 32'(s[4]), 32'(p == 6 || p == 5));
        wr(6'd8, 2);
        rd(6'd32, r); chk($sformatf("R9 vec%0d cleared", v), r, 0);
        wr(6'd9, 0); wr(6'd10, 0);
        rd(6'd0, s);
        chk($sformatf("R10 vec%0d flags", v), 32'(s[4:3]), 0);
      end
    end

    // R3 wide key value whose low bits name a valid slot
    configure(8, 32'h100);
    rd(6'd0, s); chk("R3 wide key", 32'(s[1]), 1);

    // multi-block session; no sequence error yet
    configure(8, 0);
    rd(6'd0, s); chk("R4 match", 32'(s[2:1]), 0);
    loadBlock(32'hA000);
    chk("R5 first tag", 32'(lastType), 0);
    wr(6'd5, 0);
    loadBlock(32'hB000);
    chk("R6 normal tag", 32'(lastType), 1);
    rd(6'd0, s); chk("R11 no seq error yet", 32'(s[2]), 0);
    sc = startCount;
    wr(6'd7, 0);                         // R7 illegal after two blocks
    rd(6'd0, s); chk("R7 seq error", 32'(s[2]), 1);
    rd(6'd32, r); chk("R7 no result", r, 0);
    wr(6'd6, 0);
    loadBlock(32'hC000);
    chk("R6 padded tag", 32'(lastType), 2);
    chk("R6 one start", 32'(startCount - sc), 1);
    rd(6'd32, r); chk("R6 result0", r, digWord(32'hC000, 2, 0));
    wr(6'd8, 1);                         // R9 wrong finish code ignored
    rd(6'd36, r); chk("R9 ignored code", r, digWord(32'hC000, 2, 4));
    wr(6'd8, 2);
    rd(6'd36, r); chk("R9 finish", r, 0);

    // R11 run write in idle does nothing
    sc = startCount;
    wr(6'd4, 0);
    repeat (2) @(negedge clk);
    chk("R11 no start", 32'(startCount - sc), 0);
    rd(6'd0, s); chk("R11 status", s, 32'h4);

    // R2 purpose write in idle ignored: session with no purpose fails
    wr(6'd1, 7);
    wr(6'd0, 0); wr(6'd2, 1); wr(6'd3, 0);
    waitIdle();
    rd(6'd0, s); chk("R2 ignored purpose", 32'(s[1]), 1);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule